// File: doc/BRIEF.md
# Write-Only Two-Wire DAC Code Register Slave

This block is the digital front end of a 12-bit voltage-output converter. It listens on a two-wire serial bus as a write-only slave receiver. A fast system clock oversamples both bus lines, and the block works out start, repeated start and stop conditions from them. It checks the address byte and acknowledges by pulling the data line low through an open-drain enable. Accepted data arrives as byte pairs. Each pair carries a 12-bit code and a 2-bit power-down selector, and each complete pair is committed to the active output register.

The first byte of a pair is loaded into a holding register. The active code and mode change only when the acknowledge of the second byte ends, and a one-cycle update strobe marks that moment. A pair cut short by a stop or a repeated start is dropped. The block also recognises a high-speed master code and reports high-speed operation until the next stop.

Top module: `dac_wr_slave`

## Requirements
- R1: After reset, the code is 0, the mode is 0, the update strobe is low, the high-speed flag is low and the block does not pull the data line low.
- R2: An address byte of {1,0,0,1,1,0,A,0} (MSB first, A = level of addrSel) is acknowledged. A byte with the wrong A bit, or with the last bit 1 (read), is not acknowledged, and no byte is acknowledged until the next start.
- R3: The address byte 0x90 is acknowledged at either level of addrSel.
- R4: The general-call byte 0x00 is not acknowledged, and the bytes that follow it cause no acknowledge and no update.
- R5: The acknowledge is driven for the ninth clock pulse of each accepted byte and released otherwise. The drive changes only while SCL is low.
- R6: The first data byte is taken as bits[5:4] = mode and bits[3:0] = code[11:8]. The second byte is code[7:0]. Both move to the outputs together, with a one-cycle strobe, after the falling SCL edge that ends the second byte's acknowledge, and at no other time.
- R7: Pairs sent back to back after one address each produce their own update.
- R8: A stop or repeated start after only the first byte of a pair discards it and leaves the outputs unchanged.
- R9: After a repeated start the block matches an address again. A non-matching address then blocks the bytes that follow, and a matching one starts new pairs.
- R10: An address-phase byte of the form 00001xxx is not acknowledged and sets the high-speed flag. The flag stays set across a repeated start and the transfer that follows, and clears at stop.
- R11: All four mode values reach the mode output unchanged: 00 normal, 01 1k to ground, 10 100k to ground, 11 high impedance.
- R12: Pulses shorter than FILT_CNT system clocks on SCL or SDA have no effect on the received data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Serial clock line as seen at the pin |
| sdaIn | input | 1 | Serial data line as seen at the pin |
| addrSel | input | 1 | Selects the low address bit |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls the data line low |
| dacCode | output | 12 | Active converter code |
| pdMode | output | 2 | Active power-down selector |
| updStrobe | output | 1 | One-cycle pulse when the active register loads |
| hsMode | output | 1 | High-speed master code seen since the last stop |

## Verification
The bench targets these cases:
- A pair cut off after its first byte, by a stop or by a repeated start. A design that committed early would move the code to a half-built value.
- A read-bit address, a wrong select bit and the general-call byte. A loose address compare would acknowledge these and then accept the trailing bytes.
- A high-speed code followed by a repeated start. A design that cleared the flag on any start, or acknowledged the code, would be caught.
- Narrow spikes on both lines in the middle of a byte. Without the filter these spikes add a bit or fake a start or stop.

// File: rtl/dac_slave_pkg.sv
package dac_slave_pkg;
  localparam int BYTE_W = 8;
  localparam logic [5:0] ADDR_STEM = 6'b100110;
  localparam logic [7:0] BCAST_ADDR = 8'h90;
  localparam logic [4:0] HS_PREFIX = 5'b00001;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic loadHi;
    logic commit;
  } dpCtl_t;

  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_HI, ST_LO, ST_SKIP} rxState_t;
endpackage

// File: rtl/dac_line_filter.sv
module dac_line_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CNT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);
  localparam int CW = $clog2(FILT_CNT + 1);
  logic [SYNC_STAGES-1:0] syncQ;
  logic [CW-1:0] cnt;
  logic syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '1;
      cleanOut <= 1'b1;
      cnt <= '0;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      if (syncOut == cleanOut) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_CNT - 1)) begin
        cleanOut <= syncOut;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_slave_ctrl.sv
module dac_slave_ctrl
  import dac_slave_pkg::*;
#(
  parameter int FILT_CNT = 12
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrSel,
  input  logic [BYTE_W-1:0] rxByte,
  output dpCtl_t ctl,
  output logic ackDrive,
  output logic hsMode
);
  localparam int LINES = 2;
  logic [LINES-1:0] rawLines, fltLines;
  logic sclF, sdaF, prevScl, prevSda;
  logic [1:0] a0Sync;
  logic startEv, stopEv, sclRise, sclFall, receiving, addrHit, hsCode;
  rxState_t state;
  logic [3:0] bitCnt;
  logic commitPend;

  assign rawLines = {sclIn, sdaIn};
  for (genvar g = 0; g < LINES; g++) begin : gLine
    dac_line_filter #(.SYNC_STAGES(2), .FILT_CNT(FILT_CNT)) uFilt (
      .clk(clk), .rstN(rstN), .rawIn(rawLines[g]), .cleanOut(fltLines[g]));
  end
  assign sclF = fltLines[1];
  assign sdaF = fltLines[0];

  assign startEv = sclF & prevScl & prevSda & ~sdaF;
  assign stopEv = sclF & prevScl & ~prevSda & sdaF;
  assign sclRise = sclF & ~prevScl;
  assign sclFall = ~sclF & prevScl;
  assign receiving = (state == ST_ADDR) || (state == ST_HI) || (state == ST_LO);
  assign addrHit = (rxByte == {ADDR_STEM, a0Sync[1], 1'b0}) || (rxByte == BCAST_ADDR);
  assign hsCode = (rxByte[7:3] == HS_PREFIX);

  always_comb begin
    ctl.shiftEn = receiving && sclRise && (bitCnt < 4'd8);
    ctl.shiftBit = sdaF;
    ctl.loadHi = (state == ST_HI) && sclFall && (bitCnt == 4'd8);
    ctl.commit = commitPend && sclFall && (bitCnt == 4'd9);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
      a0Sync <= '0;
      state <= ST_IDLE;
      bitCnt <= '0;
      ackDrive <= 1'b0;
      commitPend <= 1'b0;
      hsMode <= 1'b0;
    end else begin
      prevScl <= sclF;
      prevSda <= sdaF;
      a0Sync <= {a0Sync[0], addrSel};
      if (startEv) begin
        state <= ST_ADDR;
        bitCnt <= '0;
        ackDrive <= 1'b0;
        commitPend <= 1'b0;
      end else if (stopEv) begin
        state <= ST_IDLE;
        bitCnt <= '0;
        ackDrive <= 1'b0;
        commitPend <= 1'b0;
        hsMode <= 1'b0;
      end else if (sclRise && receiving && bitCnt < 4'd8) begin
        bitCnt <= bitCnt + 1'b1;
      end else if (sclFall && receiving && bitCnt == 4'd8) begin
        bitCnt <= 4'd9;
        unique case (state)
          ST_ADDR: begin
            if (addrHit) begin
              ackDrive <= 1'b1;
              state <= ST_HI;
            end else begin
              if (hsCode) hsMode <= 1'b1;
              state <= ST_SKIP;
            end
          end
          ST_HI: begin
            ackDrive <= 1'b1;
            state <= ST_LO;
          end
          default: begin
            ackDrive <= 1'b1;
            commitPend <= 1'b1;
            state <= ST_HI;
          end
        endcase
      end else if (sclFall && bitCnt == 4'd9) begin
        bitCnt <= '0;
        ackDrive <= 1'b0;
        commitPend <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/dac_slave_dp.sv
module dac_slave_dp
  import dac_slave_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  dpCtl_t ctl,
  output logic [BYTE_W-1:0] rxByte,
  output logic [CODE_W-1:0] dacCode,
  output logic [MODE_W-1:0] pdMode,
  output logic updStrobe
);
  localparam int HI_BITS = CODE_W - BYTE_W;
  logic [BYTE_W-1:0] shiftReg, holdHi;

  assign rxByte = shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      holdHi <= '0;
      dacCode <= '0;
      pdMode <= '0;
      updStrobe <= 1'b0;
    end else begin
      updStrobe <= ctl.commit;
      if (ctl.shiftEn) shiftReg <= {shiftReg[BYTE_W-2:0], ctl.shiftBit};
      if (ctl.loadHi) holdHi <= shiftReg;
      if (ctl.commit) begin
        dacCode <= {holdHi[HI_BITS-1:0], shiftReg};
        pdMode <= holdHi[HI_BITS +: MODE_W];
      end
    end
  end
endmodule

// File: rtl/dac_wr_slave.sv
module dac_wr_slave #(
  parameter int FILT_CNT = 12,
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic sclIn,
  input  logic sdaIn,
  input  logic addrSel,
  output logic sdaPullLow,
  output logic [CODE_W-1:0] dacCode,
  output logic [MODE_W-1:0] pdMode,
  output logic updStrobe,
  output logic hsMode
);
  dac_slave_pkg::dpCtl_t ctl;
  logic [dac_slave_pkg::BYTE_W-1:0] rxByte;

  dac_slave_ctrl #(.FILT_CNT(FILT_CNT)) uCtrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .addrSel(addrSel),
    .rxByte(rxByte), .ctl(ctl), .ackDrive(sdaPullLow), .hsMode(hsMode));

  dac_slave_dp #(.CODE_W(CODE_W), .MODE_W(MODE_W)) uDp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .rxByte(rxByte),
    .dacCode(dacCode), .pdMode(pdMode), .updStrobe(updStrobe));
endmodule

// File: rtl/dac_wr_slave_chk.sv
module dac_wr_slave_chk #(
  parameter int CODE_W = 12,
  parameter int MODE_W = 2
) (
  input logic clk,
  input logic rstN,
  input logic sclIn,
  input logic sdaPullLow,
  input logic [CODE_W-1:0] dacCode,
  input logic [MODE_W-1:0] pdMode,
  input logic updStrobe
);
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |=> !updStrobe); // R6
  AST_STROBE_AT_ACK_END: assert property (@(posedge clk) disable iff (!rstN)
    updStrobe |-> $fell(sdaPullLow)); // R6
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !updStrobe |-> ($stable(dacCode) && $stable(pdMode))); // R8
  AST_ACK_RISE_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaPullLow) |-> !sclIn); // R5
  AST_ACK_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sdaPullLow) |-> !sclIn); // R5
endmodule

bind dac_wr_slave dac_wr_slave_chk #(.CODE_W(CODE_W), .MODE_W(MODE_W)) u_chk (
  .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaPullLow(sdaPullLow),
  .dacCode(dacCode), .pdMode(pdMode), .updStrobe(updStrobe));

// File: tb/dac_wr_slave_bench.sv
`timescale 1ns/1ps
module dac_wr_slave_bench;
  localparam int Q = 25;
  localparam int WIN = 24;
  logic clk = 1'b0, rstN = 1'b0;
  logic sclM = 1'b1, sdaM = 1'b1, a0 = 1'b0;
  logic sdaBus, sdaPullLow, updStrobe, hsMode;
  logic [11:0] dacCode;
  logic [1:0] pdMode;

  always #2 clk = ~clk;
  assign sdaBus = sdaM & ~sdaPullLow;

  dac_wr_slave u_dac_wr_slave (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .addrSel(a0),
    .sdaPullLow(sdaPullLow), .dacCode(dacCode), .pdMode(pdMode),
    .updStrobe(updStrobe), .hsMode(hsMode));

  int nCmp = 0, nBad = 0;
  bit done = 0;
  // reference model state
  int mPhase = 0;  // 0 idle/skip, 1 address, 2 first byte, 3 second byte
  logic [7:0] mHold = 8'h00;
  logic [11:0] expCode = '0;
  logic [1:0] expMode = '0;
  bit expHs = 0;
  int settle = 0, wantStrobe = 0, seenStrobe = 0;

  task automatic chk(bit ok, string tag, int act, int exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic arm(int strobes);
    wantStrobe = strobes;
    seenStrobe = 0;
    settle = WIN;
  endtask

  // per-clock comparison against the model
  always begin
    @(posedge clk);
    #1;
    if (rstN && !done) begin
      if (settle > 0) begin
        if (updStrobe) seenStrobe++;
        settle--;
        if (settle == 0) chk(seenStrobe == wantStrobe, "R6 strobe count", seenStrobe, wantStrobe);
      end else begin
        chk(dacCode == expCode, "R6 code", dacCode, expCode);
        chk(pdMode == expMode, "R11 mode", pdMode, expMode);
        chk(hsMode == expHs, "R10 hs flag", hsMode, expHs);
        chk(updStrobe == 1'b0, "R6 stray strobe", updStrobe, 0);
      end
    end
  end

  task automatic busStart();
    sdaM = 1'b0; hold(Q);
    sclM = 1'b0; hold(Q);
    mPhase = 1;
  endtask

  task automatic busRestart();
    sdaM = 1'b1; hold(Q);
    sclM = 1'b1; hold(Q);
    sdaM = 1'b0; hold(Q);
    sclM = 1'b0; hold(Q);
    mPhase = 1;
  endtask

  task automatic busStop();
    sdaM = 1'b0; hold(Q);
    sclM = 1'b1; hold(Q);
    sdaM = 1'b1;
    mPhase = 0;
    expHs = 0;
    arm(0);
    hold(2 * Q);
  endtask

  // model decision at the end of the eighth bit
  task automatic modelByte(input logic [7:0] b, output bit ack, output bit commit);
    ack = 0;
    commit = 0;
    case (mPhase)
      1: begin
        if (b == {6'b100110, a0, 1'b0} || b == 8'h90) begin
          ack = 1; mPhase = 2;
        end else begin
          if (b[7:3] == 5'b00001) begin
            expHs = 1; arm(0);
          end
          mPhase = 0;
        end
      end
      2: begin ack = 1; mHold = b; mPhase = 3; end
      3: begin ack = 1; commit = 1; mPhase = 2; end
      default: ;
    endcase
  endtask

  task automatic sendByte(input logic [7:0] b, input string tag, input bit glitch = 0);
    bit ack, commit;
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i];
      if (glitch && i == 4) begin
        hold(8); sclM = 1'b1; hold(5); sclM = 1'b0; hold(Q - 13);
      end else hold(Q);
      sclM = 1'b1;
      if (glitch && i == 3) begin
        hold(10); sdaM = ~b[i]; hold(5); sdaM = b[i]; hold(Q - 15);
      end else hold(Q);
      chk(sdaPullLow == 1'b0, "R5 released during data", sdaPullLow, 0);
      hold(Q);
      sclM = 1'b0;
      if (i == 0) modelByte(b, ack, commit);
      hold(Q);
    end
    sdaM = 1'b1; hold(Q);
    sclM = 1'b1; hold(Q);
    chk(sdaPullLow == ack, tag, sdaPullLow, ack);
    hold(Q);
    sclM = 1'b0;
    if (commit) begin
      expCode = {mHold[3:0], b};
      expMode = mHold[5:4];
      arm(1);
    end
    hold(Q);
  endtask

  initial begin
    hold(10);
    rstN = 1'b1;
    hold(3);
    chk(dacCode == 0 && pdMode == 0 && !updStrobe && !hsMode && !sdaPullLow,
        "R1 reset state", {dacCode, pdMode}, 0);
    hold(20);
    // R2 R6: single write
    busStart(); sendByte(8'h98, "R2 address ack");
    sendByte(8'h0A, "R5 first byte ack"); sendByte(8'hBC, "R6 second byte ack"); busStop();
    // R7 R11: back-to-back pairs through all modes
    busStart(); sendByte(8'h98, "R2 address ack");
    sendByte(8'h15, "R7 ack"); sendByte(8'h67, "R7 ack");
    sendByte(8'h2F, "R11 ack"); sendByte(8'hFF, "R11 ack");
    sendByte(8'h30, "R11 ack"); sendByte(8'h00, "R11 ack"); busStop();
    // R2: wrong select bit, then matching with A=1
    a0 = 1'b1; hold(10);
    busStart(); sendByte(8'h98, "R2 wrong select nack");
    sendByte(8'h01, "R2 ignored byte"); sendByte(8'h23, "R2 ignored byte"); busStop();
    busStart(); sendByte(8'h9A, "R2 address ack A=1");
    sendByte(8'h04, "R2 ack"); sendByte(8'h56, "R2 ack"); busStop();
    // R3: broadcast with A=1
    busStart(); sendByte(8'h90, "R3 broadcast ack");
    sendByte(8'h07, "R3 ack"); sendByte(8'h89, "R3 ack"); busStop();
    // R2: read bit refused
    busStart(); sendByte(8'h9B, "R2 read nack"); sendByte(8'h02, "R2 ignored"); busStop();
    // R4: general call refused
    busStart(); sendByte(8'h00, "R4 general call nack");
    sendByte(8'h05, "R4 ignored"); sendByte(8'h55, "R4 ignored"); busStop();
    // R8: partial pair then stop, then partial then restart
    busStart(); sendByte(8'h9A, "R8 ack"); sendByte(8'h0D, "R8 first byte"); busStop();
    busStart(); sendByte(8'h9A, "R8 ack"); sendByte(8'h0E, "R8 first byte");
    busRestart(); sendByte(8'h9A, "R9 readdress ack");
    sendByte(8'h01, "R9 ack"); sendByte(8'h11, "R9 ack");
    busRestart(); sendByte(8'h00, "R9 readdress nack"); sendByte(8'h0F, "R9 ignored");
    sendByte(8'hFF, "R9 ignored"); busStop();
    // R10: high-speed master code
    busStart(); sendByte(8'h0B, "R10 master code nack");
    busRestart(); sendByte(8'h9A, "R10 address ack");
    sendByte(8'h02, "R10 ack"); sendByte(8'h22, "R10 ack"); busStop();
    // R12: spikes inside the first data byte
    busStart(); sendByte(8'h9A, "R12 ack");
    sendByte(8'h0C, "R12 glitched byte ack", 1'b1); sendByte(8'h33, "R12 ack"); busStop();
    hold(40);
    chk(dacCode == 12'hC33, "R12 final code", dacCode, 12'hC33);
    finishRun();
  end

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nCmp++; nBad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finishRun();
  end
endmodule